// File: doc/BRIEF.md
# Two-Word Burst Quad-Rate Memory Port

This block models a static memory with one read data bus and one separate write data bus. Every access moves a pair of words. The bus clock pair and its complement are modelled as alternating phases of one internal clock that runs at twice the bus rate. The internal phase counter starts on the bus "K" phase after reset. Even edges counted from reset release are K phases and odd edges are complement-K phases.

A read is taken on a K phase, together with its address. A write is taken on the same K phase, but its address and its second data word arrive on the following complement-K phase. Write data can be masked per lane, and each word of the pair has its own mask. Read data comes back one bus period later on the chosen output reference phases, while the pair of echo clocks runs without pause. The memory is organised as `DEPTH` entries, and each entry holds one word pair. The base address selects the entry, and the word index 0 or 1 is implied by the beat. The data width is limited to 8, 18 or 36 bits.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is held and right after it is released, `q_oe` is 0, `q` is 0, `cq_n` equals `oref_c` and `cq` is its complement.
- R2: With `oref_c`=0, a read taken when `rd_n` is 0 on a K edge drives word 0 of the addressed pair on `q` after the next K edge (two clocks later) and word 1 after the complement-K edge after that. `q_oe` is 1 for exactly those two beats. At all other times `q` is 0 and `q_oe` is 0.
- R3: A write is taken when `wr_n` is 0 on a K edge. Word 0 and its mask are captured at that edge. The write address, word 1 and its mask are captured at the following complement-K edge. The address present at the K edge of a write plays no part.
- R4: `be_n` is active low. Lane i covers data bits [i*LW +: LW], with LW=4 for an 8-bit width and LW=9 otherwise. For each word, a lane with its bit at 1 keeps its stored value. The mask sampled at the K edge applies to word 0, and the mask sampled at the complement-K edge applies to word 1.
- R5: With `oref_c`=1, read beats come one clock later than under R2. Word 0 appears after the complement-K edge that follows the next K edge, and word 1 appears after the K edge after that.
- R6: `cq_n` rises at each edge that launches a word-0 slot, and `cq` rises at each edge that launches a word-1 slot. Both run every cycle whether or not a read is active, and `cq` is always the complement of `cq_n`.
- R7: When `rd_n` and `wr_n` are both 1 at a K edge, `addr`, `wdata` and `be_n` change no stored data and no read beats appear.
- R8: A read and a write to the same address taken at the same K edge return the pair stored before that write. A later read returns the new pair.
- R9: Reads taken at consecutive K edges give four consecutive beats with `q_oe` held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the bus rate; edges alternate K and complement-K |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read select, sampled on K edges |
| wr_n | input | 1 | Active-low write select, sampled on K edges |
| addr | input | ADDR_W | Pair address: read address on K edge, write address on complement-K edge |
| wdata | input | DATA_W | Write data, word 0 on K edge, word 1 on complement-K edge |
| be_n | input | LANES | Active-low lane write enables, sampled per data edge |
| oref_c | input | 1 | Output reference: 0 = K phases, 1 = output-clock phases (static during traffic) |
| q | output | DATA_W | Read data beats, 0 when idle |
| q_oe | output | 1 | High while a read beat is on `q` |
| cq | output | 1 | Echo clock, rises with word-1 slots |
| cq_n | output | 1 | Echo clock complement, rises with word-0 slots |

## Verification
The bench places the write address at the K edge different from the one at the complement-K edge. A design that latched the wrong edge would corrupt a second location or miss the target. It writes masks that differ between the two words, so that a mask applied to the wrong beat shows up as a mixed word. A read and a write to the same address at the same edge must return the old pair; forwarding logic would return the new one. Back-to-back reads check that a new read does not overwrite the buffer of the one still being driven. Runs in both output-reference modes catch launch slots or echo phases that are off by one clock.

// File: rtl/qdr_burst_pkg.sv
package qdr_burst_pkg;

   // lane width per supported data width: nibbles on 8, 9-bit bytes otherwise
   function automatic int lane_width(input int w);
      return (w == 8) ? 4 : 9;
   endfunction

   typedef enum logic {
      PH_K  = 1'b0,
      PH_KN = 1'b1
   } phase_e;

endpackage

// File: rtl/qdr_phase_cmd.sv
module qdr_phase_cmd
   import qdr_burst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic k_edge,
   output logic rd_take,
   output logic wr_take,
   output logic wr_commit
);

   phase_e ph_q;
   logic   wr_pend;

   // phase sequencer: first edge after reset is a K edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_K;
      else        ph_q <= (ph_q == PH_K) ? PH_KN : PH_K;
   end

   assign k_edge  = (ph_q == PH_K);
   assign rd_take = k_edge & ~rd_n;
   assign wr_take = k_edge & ~wr_n;

   // write accepted on K, committed on following complement-K
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wr_pend <= 1'b0;
      else if (k_edge) wr_pend <= ~wr_n;
      else             wr_pend <= 1'b0;
   end

   assign wr_commit = wr_pend & ~k_edge;

   assert_wr_on_kn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pend |-> !k_edge);

   assert_wr_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pend |-> !$past(wr_n));

endmodule

// File: rtl/qdr_pair_store.sv
module qdr_pair_store
   import qdr_burst_pkg::*;
#(
   parameter  int DATA_W = 18,
   parameter  int DEPTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LW     = lane_width(DATA_W),
   localparam int LANES  = DATA_W / LW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_take,
   input  logic                wr_commit,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [LANES-1:0]    be_n,
   output logic [2*DATA_W-1:0] rd_pair
);

   logic [2*DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0]   wd0_q;
   logic [LANES-1:0]    wb0_q;
   logic [2*DATA_W-1:0] cur_pair;
   logic [2*DATA_W-1:0] nxt_pair;

   // word 0 and its mask held from the K edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd0_q <= '0;
         wb0_q <= '1;
      end else if (wr_take) begin
         wd0_q <= wdata;
         wb0_q <= be_n;
      end
   end

   assign cur_pair = mem[addr];

   // lane merge: word 0 in low half, word 1 in high half
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign nxt_pair[l*LW +: LW] =
         wb0_q[l] ? cur_pair[l*LW +: LW] : wd0_q[l*LW +: LW];
      assign nxt_pair[DATA_W + l*LW +: LW] =
         be_n[l] ? cur_pair[DATA_W + l*LW +: LW] : wdata[l*LW +: LW];
   end

   always_ff @(posedge clk) begin
      if (wr_commit) mem[addr] <= nxt_pair;
   end

   assign rd_pair = cur_pair;

endmodule

// File: rtl/qdr_read_launch.sv
module qdr_read_launch #(
   parameter int DATA_W = 18
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                k_edge,
   input  logic                oref_c,
   input  logic                rd_take,
   input  logic [2*DATA_W-1:0] rd_pair,
   output logic [DATA_W-1:0]   q,
   output logic                q_oe,
   output logic                cq,
   output logic                cq_n
);

   logic [2*DATA_W-1:0] rbuf_q, obuf_q, src_pair;
   logic                rpend_q, ov_q, src_v;
   logic [DATA_W-1:0]   hold_q, q_r;
   logic                beat1_q, oe_r, cqn_r, slot0;

   // read capture on K edge, plus one-period stage for output-clock mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbuf_q  <= '0;
         obuf_q  <= '0;
         rpend_q <= 1'b0;
         ov_q    <= 1'b0;
      end else if (k_edge) begin
         rpend_q <= rd_take;
         if (rd_take) rbuf_q <= rd_pair;
         obuf_q  <= rbuf_q;
         ov_q    <= rpend_q;
      end
   end

   // first-word slot: K edges in K mode, complement-K edges in C mode
   assign slot0    = oref_c ? ~k_edge : k_edge;
   assign src_v    = oref_c ? ov_q : rpend_q;
   assign src_pair = oref_c ? obuf_q : rbuf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r     <= '0;
         oe_r    <= 1'b0;
         hold_q  <= '0;
         beat1_q <= 1'b0;
         cqn_r   <= oref_c;
      end else begin
         cqn_r <= slot0;
         if (slot0) begin
            q_r     <= src_v ? src_pair[DATA_W-1:0] : '0;
            oe_r    <= src_v;
            hold_q  <= src_pair[2*DATA_W-1:DATA_W];
            beat1_q <= src_v;
         end else begin
            q_r     <= beat1_q ? hold_q : '0;
            oe_r    <= beat1_q;
            beat1_q <= 1'b0;
         end
      end
   end

   assign q    = q_r;
   assign q_oe = oe_r;
   assign cq_n = cqn_r;
   assign cq   = ~cqn_r;

   assert_beat_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_oe) |=> q_oe);

   assert_k_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 3) && $past(rd_take, 3) && !oref_c && !$past(oref_c, 3)) |-> q_oe);

   assert_c_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 4) && $past(rd_take, 4) && oref_c && $past(oref_c, 4)) |-> q_oe);

   assert_echo_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(oref_c) == $past(oref_c, 2))) |-> (cq_n != $past(cq_n)));

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
   import qdr_burst_pkg::*;
#(
   parameter  int DATA_W = 18,
   parameter  int DEPTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LW     = lane_width(DATA_W),
   localparam int LANES  = DATA_W / LW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  be_n,
   input  logic              oref_c,
   output logic [DATA_W-1:0] q,
   output logic              q_oe,
   output logic              cq,
   output logic              cq_n
);

   if (!(DATA_W == 8 || DATA_W == 18 || DATA_W == 36)) begin : g_bad_width
      $error("DATA_W must be 8, 18 or 36");
   end
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end

   logic                k_edge, rd_take, wr_take, wr_commit;
   logic [2*DATA_W-1:0] rd_pair;

   qdr_phase_cmd u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .k_edge    (k_edge),
      .rd_take   (rd_take),
      .wr_take   (wr_take),
      .wr_commit (wr_commit)
   );

   qdr_pair_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_take   (wr_take),
      .wr_commit (wr_commit),
      .addr      (addr),
      .wdata     (wdata),
      .be_n      (be_n),
      .rd_pair   (rd_pair)
   );

   qdr_read_launch #(.DATA_W(DATA_W)) u_launch (
      .clk     (clk),
      .rst_n   (rst_n),
      .k_edge  (k_edge),
      .oref_c  (oref_c),
      .rd_take (rd_take),
      .rd_pair (rd_pair),
      .q       (q),
      .q_oe    (q_oe),
      .cq      (cq),
      .cq_n    (cq_n)
   );

endmodule

// File: tb/sim_qdr_burst_sram.sv
module sim_qdr_burst_sram;

   localparam int W     = 18;
   localparam int DEPTH = 64;
   localparam int AW    = $clog2(DEPTH);
   localparam int LANES = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_n = 1'b1, wr_n = 1'b1, oref_c = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  wdata = '0;
   logic [LANES-1:0] be_n = '1;
   logic [W-1:0]  q;
   logic          q_oe, cq, cq_n;

   int nchk = 0, nfail = 0, ecnt = 0;

   always #5 clk = ~clk;
   always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

   qdr_burst_sram #(.DATA_W(W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .be_n(be_n), .oref_c(oref_c), .q(q), .q_oe(q_oe),
      .cq(cq), .cq_n(cq_n));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reach a negedge whose next posedge is a K edge
   task automatic sync_k();
      @(negedge clk);
      while (ecnt % 2 != 0) @(negedge clk);
   endtask

   task automatic wr_pair(input [AW-1:0] a, input [AW-1:0] k_addr, input [W-1:0] w0,
                          input [LANES-1:0] b0, input [W-1:0] w1, input [LANES-1:0] b1);
      sync_k();
      wr_n = 1'b0; addr = k_addr; wdata = w0; be_n = b0;
      @(negedge clk);
      wr_n = 1'b1; addr = a; wdata = w1; be_n = b1;
      @(negedge clk);
      addr = '0; wdata = '0; be_n = '1;
   endtask

   task automatic rd_chk(input [AW-1:0] a, input [W-1:0] e0, input [W-1:0] e1, input string tag);
      int first;
      first = oref_c ? 4 : 3;
      sync_k();
      rd_n = 1'b0; addr = a;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (k == 1) begin rd_n = 1'b1; addr = '0; end
         if (k == first)
            chk(q_oe && q == e0, {tag, " word0"}, {q_oe, q}, {1'b1, e0});
         else if (k == first + 1)
            chk(q_oe && q == e1, {tag, " word1"}, {q_oe, q}, {1'b1, e1});
         else
            chk(!q_oe && q == '0, {tag, " idle"}, {q_oe, q}, 0);
      end
   endtask

   task automatic t_reset();
      chk(!q_oe && q == '0, "R1 outputs in reset", {q_oe, q}, 0);
      chk(cq_n == oref_c && cq == ~cq_n, "R1 echo in reset", {cq, cq_n}, {~oref_c, oref_c});
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      chk(!q_oe && q == '0, "R1 outputs after release", {q_oe, q}, 0);
   endtask

   task automatic t_basic();
      wr_pair(6'd5, 6'd9, 18'h12345, 2'b00, 18'h2ABCD, 2'b00);
      rd_chk(6'd5, 18'h12345, 18'h2ABCD, "R2 K-mode read");
      wr_pair(6'd9, 6'd9, 18'h0F0F0, 2'b00, 18'h30303, 2'b00);
      // K-edge address 9 must not be the target (R3)
      wr_pair(6'd7, 6'd9, 18'h11111, 2'b00, 18'h22222, 2'b00);
      rd_chk(6'd7, 18'h11111, 18'h22222, "R3 write address from complement-K");
      rd_chk(6'd9, 18'h0F0F0, 18'h30303, "R3 K-edge address untouched");
   endtask

   task automatic t_lanes();
      logic [W-1:0] o0, o1, n0, n1;
      o0 = 18'h12345; o1 = 18'h2ABCD; n0 = 18'h3FFFF; n1 = 18'h00000;
      wr_pair(6'd12, 6'd0, o0, 2'b00, o1, 2'b00);
      wr_pair(6'd12, 6'd0, n0, 2'b10, n1, 2'b01);
      rd_chk(6'd12, {o0[17:9], n0[8:0]}, {n1[17:9], o1[8:0]}, "R4 per-word lane masks");
      wr_pair(6'd12, 6'd0, 18'h0, 2'b11, 18'h3FFFF, 2'b11);
      rd_chk(6'd12, {o0[17:9], n0[8:0]}, {n1[17:9], o1[8:0]}, "R4 all lanes masked");
   endtask

   task automatic t_echo(input string tag);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         // last edge was K when ecnt is odd
         chk(cq_n == (oref_c ? (ecnt % 2 == 0) : (ecnt % 2 == 1)) && cq == ~cq_n,
             tag, {cq, cq_n}, {~cq_n, cq_n});
      end
   endtask

   task automatic t_cmode();
      sync_k(); oref_c = 1'b1;
      @(negedge clk); @(negedge clk);
      t_echo("R6 echo in output-clock mode");
      rd_chk(6'd5, 18'h12345, 18'h2ABCD, "R5 output-clock mode read");
      sync_k(); oref_c = 1'b0;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic t_desel();
      wr_pair(6'd20, 6'd0, 18'h0AAAA, 2'b00, 18'h15555, 2'b00);
      sync_k();
      for (int k = 0; k < 6; k++) begin
         addr = 6'd20; wdata = 18'h3C3C3; be_n = '0;
         @(negedge clk);
         chk(!q_oe && q == '0, "R7 deselected, no beats", {q_oe, q}, 0);
      end
      addr = '0; wdata = '0; be_n = '1;
      rd_chk(6'd20, 18'h0AAAA, 18'h15555, "R7 deselected, data kept");
   endtask

   task automatic t_same();
      wr_pair(6'd30, 6'd0, 18'h01234, 2'b00, 18'h05678, 2'b00);
      sync_k();
      rd_n = 1'b0; wr_n = 1'b0; addr = 6'd30; wdata = 18'h39ABC; be_n = '0;
      @(negedge clk);
      rd_n = 1'b1; wr_n = 1'b1; wdata = 18'h3DEF0;
      @(negedge clk);
      addr = '0; wdata = '0; be_n = '1;
      @(negedge clk);
      chk(q_oe && q == 18'h01234, "R8 same-cycle read gets old word0", {q_oe, q}, {1'b1, 18'h01234});
      @(negedge clk);
      chk(q_oe && q == 18'h05678, "R8 same-cycle read gets old word1", {q_oe, q}, {1'b1, 18'h05678});
      rd_chk(6'd30, 18'h39ABC, 18'h3DEF0, "R8 later read gets new pair");
   endtask

   task automatic t_b2b();
      sync_k();
      rd_n = 1'b0; addr = 6'd5;
      @(negedge clk); rd_n = 1'b1;
      @(negedge clk); rd_n = 1'b0; addr = 6'd7;
      @(negedge clk); rd_n = 1'b1; addr = '0;
      chk(q_oe && q == 18'h12345, "R9 beat 1", {q_oe, q}, {1'b1, 18'h12345});
      @(negedge clk);
      chk(q_oe && q == 18'h2ABCD, "R9 beat 2", {q_oe, q}, {1'b1, 18'h2ABCD});
      @(negedge clk);
      chk(q_oe && q == 18'h11111, "R9 beat 3", {q_oe, q}, {1'b1, 18'h11111});
      @(negedge clk);
      chk(q_oe && q == 18'h22222, "R9 beat 4", {q_oe, q}, {1'b1, 18'h22222});
      @(negedge clk);
      chk(!q_oe && q == '0, "R9 bus idle after", {q_oe, q}, 0);
   endtask

   initial begin
      #2_000_000;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_echo("R6 echo in K mode");
      t_basic();
      t_lanes();
      t_cmode();
      t_desel();
      t_same();
      t_b2b();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule